// File: doc/BRIEF.md
# I2C SCL Period Generator

This block times the serial clock of an I2C master. When enabled, it alternates between a low phase, during which it asks the pad to pull SCL low, and a high phase, during which it releases the line. The length of each phase comes from a programmable cycle count. The block keeps one high/low count pair for standard mode and one for fast mode, and a speed-select input chooses between them. Each phase is measured from the moment the controller pulls or releases the line, so the edge transition times count as part of the programmed phase.

A target may stretch the clock. While SCL is released and the sampled line still reads low, the high-phase counter waits. After every falling edge of SCL, the block delays the point at which SDA may change by a programmable hold count, and it marks that point with a one-cycle pulse. It also gives a one-cycle pulse at the start of every low phase and every high phase. A surrounding sequencer uses these pulses to shift data and to build start and stop conditions.

The count and hold inputs are captured only while the block is disabled. Software can therefore reprogram them freely while the controller is off, and any change made during operation is ignored.

Top module: `scl_period_gen`

## Requirements
- R1: The low phase (scl_pull_low high) lasts max(lcnt, 8) + 1 clock cycles. lcnt is the low count of the selected pair.
- R2: Without stretching, the high phase (scl_pull_low low while enabled) lasts max(hcnt, 6) + 3 clock cycles. hcnt is the high count of the selected pair.
- R3: speed_sel = 2'b00 selects the standard pair, and any other value selects the fast pair. speed_sel is sampled only when a phase starts, so a change during a phase takes effect at the next phase.
- R4: A high count below 6 behaves exactly as 6, and a low count below 8 behaves exactly as 8.
- R5: Each clock edge of the high phase at which scl_in is sampled low lengthens that high phase by exactly one cycle.
- R6: One clock edge after enable is sampled low, scl_pull_low is 0 and no pulse is produced. After enable rises, the first cycle of operation is the first cycle of a low phase.
- R7: Count and hold inputs that change while enable is high have no effect until the block has been disabled for at least one clock edge.
- R8: sda_go pulses once per low phase, min(max(hold, 1), L − 1) cycles after the first low cycle, where L is the low-phase length. A hold of 0 therefore acts as 1.
- R9: lo_edge is high only in the first cycle of each low phase, and hi_edge only in the first cycle of each high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; low releases SCL and allows the configuration to load |
| speed_sel | input | 2 | 2'b00 standard pair, any other value fast pair |
| std_hcnt | input | CNT_W | Standard-mode high count |
| std_lcnt | input | CNT_W | Standard-mode low count |
| fast_hcnt | input | CNT_W | Fast-mode high count |
| fast_lcnt | input | CNT_W | Fast-mode low count |
| sda_hold | input | HOLD_W | Cycles from the SCL fall to the SDA change point |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull_low | output | 1 | Request to drive SCL low |
| lo_edge | output | 1 | First cycle of a low phase |
| hi_edge | output | 1 | First cycle of a high phase |
| sda_go | output | 1 | SDA may change in this cycle |

## Verification
The bench builds the block with the default 16-bit count and hold widths. It drives small random counts, roughly 0 to 40, so that both sides of the clamp thresholds and many full SCL periods fit into a short run. One directed case uses a low count of 300 to exercise the upper bits of the counter. Hold values larger than the low phase reach the end-of-low fallback of the SDA timer. Stretch windows and a speed change in the middle of a phase show that the counts are sampled only at phase boundaries.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    localparam int MIN_HCNT = 6;
    localparam int MIN_LCNT = 8;
    localparam int HI_EXTRA = 3;
    localparam int LO_EXTRA = 1;
    localparam int NUM_MODES = 2;
endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow
    import scl_gen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 16,
    parameter int LIM_W  = CNT_W + 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              enable,
    input  logic [CNT_W-1:0]                  std_hcnt,
    input  logic [CNT_W-1:0]                  std_lcnt,
    input  logic [CNT_W-1:0]                  fast_hcnt,
    input  logic [CNT_W-1:0]                  fast_lcnt,
    input  logic [HOLD_W-1:0]                 sda_hold,
    output logic [NUM_MODES-1:0][LIM_W-1:0]   hi_lim,
    output logic [NUM_MODES-1:0][LIM_W-1:0]   lo_lim,
    output logic [HOLD_W-1:0]                 hold_eff
);
    typedef struct packed {
        logic [NUM_MODES-1:0][CNT_W-1:0] h;
        logic [NUM_MODES-1:0][CNT_W-1:0] l;
        logic [HOLD_W-1:0]               hold;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Shadow copies load only while the generator is stopped.
    always_comb begin
        cfg_d = cfg_q;
        if (!enable) begin
            cfg_d.h[0] = std_hcnt;
            cfg_d.l[0] = std_lcnt;
            cfg_d.h[1] = fast_hcnt;
            cfg_d.l[1] = fast_lcnt;
            cfg_d.hold = sda_hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        logic [CNT_W-1:0] h_cl;
        logic [CNT_W-1:0] l_cl;
        assign h_cl = (cfg_q.h[m] < CNT_W'(MIN_HCNT)) ? CNT_W'(MIN_HCNT) : cfg_q.h[m];
        assign l_cl = (cfg_q.l[m] < CNT_W'(MIN_LCNT)) ? CNT_W'(MIN_LCNT) : cfg_q.l[m];
        // terminal count = phase length - 1
        assign hi_lim[m] = {2'b00, h_cl} + LIM_W'(HI_EXTRA - 1);
        assign lo_lim[m] = {2'b00, l_cl} + LIM_W'(LO_EXTRA - 1);
    end

    assign hold_eff = (cfg_q.hold == '0) ? HOLD_W'(1) : cfg_q.hold;

    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> ($stable(hi_lim) && $stable(lo_lim) && $stable(hold_eff)));

    // R8
    hold_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_eff != '0);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int LIM_W = 18
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enable,
    input  logic                            fast_sel,
    input  logic                            scl_in,
    input  logic [NUM_MODES-1:0][LIM_W-1:0] hi_lim,
    input  logic [NUM_MODES-1:0][LIM_W-1:0] lo_lim,
    output scl_phase_e                      phase,
    output logic                            lo_start,
    output logic                            hi_start,
    output logic                            low_last
);
    typedef struct packed {
        scl_phase_e       ph;
        logic [LIM_W-1:0] cnt;
        logic [LIM_W-1:0] lim;
        logic             lo_p;
        logic             hi_p;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.lo_p = 1'b0;
        st_d.hi_p = 1'b0;
        if (!enable) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
            st_d.lim = '0;
        end else begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    st_d.ph   = PH_LOW;
                    st_d.cnt  = '0;
                    st_d.lim  = lo_lim[fast_sel];
                    st_d.lo_p = 1'b1;
                end
                PH_LOW: begin
                    if (st_q.cnt == st_q.lim) begin
                        st_d.ph   = PH_HIGH;
                        st_d.cnt  = '0;
                        st_d.lim  = hi_lim[fast_sel];
                        st_d.hi_p = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (!scl_in) begin
                        st_d.cnt = st_q.cnt;   // target stretches the clock
                    end else if (st_q.cnt == st_q.lim) begin
                        st_d.ph   = PH_LOW;
                        st_d.cnt  = '0;
                        st_d.lim  = lo_lim[fast_sel];
                        st_d.lo_p = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: begin
                    st_d.ph  = PH_IDLE;
                    st_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase    = st_q.ph;
    assign lo_start = st_q.lo_p;
    assign hi_start = st_q.hi_p;
    assign low_last = (st_q.ph == PH_LOW) && (st_q.cnt == st_q.lim);

    // R5
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_HIGH && enable && !scl_in) |=> (st_q.ph == PH_HIGH));

    // R6
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.ph == PH_IDLE && !st_q.lo_p && !st_q.hi_p));

    // R9
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.lo_p && st_q.hi_p));

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE) |-> (st_q.cnt <= st_q.lim));
endmodule

// File: rtl/sda_hold_timer.sv
module sda_hold_timer #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_start,
    input  logic              in_low,
    input  logic              low_last,
    input  logic [HOLD_W-1:0] hold_eff,
    output logic              sda_go
);
    typedef struct packed {
        logic [HOLD_W:0] tcnt;
        logic            armed;
    } tm_t;

    tm_t tm_d, tm_q;
    logic fire;

    assign fire = tm_q.armed && in_low && !lo_start &&
                  ((tm_q.tcnt == {1'b0, hold_eff}) || low_last);

    always_comb begin
        tm_d = tm_q;
        if (lo_start) begin
            tm_d.tcnt  = (HOLD_W+1)'(1);
            tm_d.armed = 1'b1;
        end else if (fire || !in_low) begin
            tm_d.armed = 1'b0;
        end else if (tm_q.armed) begin
            tm_d.tcnt = tm_q.tcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign sda_go = fire;

    // R8
    sda_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_go |-> in_low);

    // R8
    sda_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_go |=> !sda_go);
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        speed_sel,
    input  logic [CNT_W-1:0]  std_hcnt,
    input  logic [CNT_W-1:0]  std_lcnt,
    input  logic [CNT_W-1:0]  fast_hcnt,
    input  logic [CNT_W-1:0]  fast_lcnt,
    input  logic [HOLD_W-1:0] sda_hold,
    input  logic              scl_in,
    output logic              scl_pull_low,
    output logic              lo_edge,
    output logic              hi_edge,
    output logic              sda_go
);
    localparam int LIM_W = CNT_W + 2;

    logic [NUM_MODES-1:0][LIM_W-1:0] hi_lim;
    logic [NUM_MODES-1:0][LIM_W-1:0] lo_lim;
    logic [HOLD_W-1:0]               hold_eff;
    scl_phase_e                      phase;
    logic                            low_last;
    logic                            fast_sel;

    assign fast_sel = (speed_sel != 2'b00);

    scl_cfg_shadow #(.CNT_W(CNT_W), .HOLD_W(HOLD_W), .LIM_W(LIM_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .std_hcnt  (std_hcnt),
        .std_lcnt  (std_lcnt),
        .fast_hcnt (fast_hcnt),
        .fast_lcnt (fast_lcnt),
        .sda_hold  (sda_hold),
        .hi_lim    (hi_lim),
        .lo_lim    (lo_lim),
        .hold_eff  (hold_eff)
    );

    scl_phase_fsm #(.LIM_W(LIM_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .fast_sel (fast_sel),
        .scl_in   (scl_in),
        .hi_lim   (hi_lim),
        .lo_lim   (lo_lim),
        .phase    (phase),
        .lo_start (lo_edge),
        .hi_start (hi_edge),
        .low_last (low_last)
    );

    assign scl_pull_low = (phase == PH_LOW);

    sda_hold_timer #(.HOLD_W(HOLD_W)) u_sda (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_start (lo_edge),
        .in_low   (scl_pull_low),
        .low_last (low_last),
        .hold_eff (hold_eff),
        .sda_go   (sda_go)
    );

    // R9
    fall_marks_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> lo_edge);

    // R9
    rise_marks_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_pull_low) && enable && $past(enable)) |-> hi_edge);
endmodule

// File: tb/scl_period_gen_test.sv
module scl_period_gen_test;
    localparam int CNT_W  = 16;
    localparam int HOLD_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic [1:0]        speed_sel = 2'b00;
    logic [CNT_W-1:0]  std_hcnt = '0, std_lcnt = '0, fast_hcnt = '0, fast_lcnt = '0;
    logic [HOLD_W-1:0] sda_hold = '0;
    logic              stretch = 1'b0;
    logic              scl_in;
    logic              scl_pull_low, lo_edge, hi_edge, sda_go;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    assign scl_in = ~(scl_pull_low | stretch);

    scl_period_gen #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .speed_sel(speed_sel),
        .std_hcnt(std_hcnt), .std_lcnt(std_lcnt), .fast_hcnt(fast_hcnt),
        .fast_lcnt(fast_lcnt), .sda_hold(sda_hold), .scl_in(scl_in),
        .scl_pull_low(scl_pull_low), .lo_edge(lo_edge), .hi_edge(hi_edge),
        .sda_go(sda_go)
    );

    function automatic int f_lo(int l);
        return ((l < 8) ? 8 : l) + 1;
    endfunction

    function automatic int f_hi(int h);
        return ((h < 6) ? 6 : h) + 3;
    endfunction

    function automatic int f_sda(int hold, int lo_len);
        int he = (hold == 0) ? 1 : hold;
        return (he < lo_len - 1) ? he : lo_len - 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reconfig(input int sh, input int sl, input int fh, input int fl,
                            input int hold, input logic [1:0] sp);
        enable = 1'b0;
        std_hcnt = CNT_W'(sh); std_lcnt = CNT_W'(sl);
        fast_hcnt = CNT_W'(fh); fast_lcnt = CNT_W'(fl);
        sda_hold = HOLD_W'(hold); speed_sel = sp;
        @(negedge clk); @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    // Measures one low phase followed by one high phase.
    task automatic measure(input int flip_at, input int st_at, input int st_len,
                           output int lo_len, output int hi_len, output int sda_off,
                           output int extra_edges, output bit hi_first);
        int guard = 0;
        while (!lo_edge && guard < 5000) begin @(negedge clk); guard++; end
        lo_len = 0; sda_off = -1; extra_edges = 0;
        while (scl_pull_low && lo_len < 5000) begin
            if (sda_go && sda_off < 0) sda_off = lo_len;
            if ((lo_edge && lo_len != 0) || hi_edge) extra_edges++;
            if (lo_len == flip_at) speed_sel = (speed_sel == 2'b00) ? 2'b10 : 2'b00;
            lo_len++;
            @(negedge clk);
        end
        hi_first = hi_edge;
        hi_len = 0;
        while (!scl_pull_low && hi_len < 5000) begin
            if ((hi_edge && hi_len != 0) || lo_edge || sda_go) extra_edges++;
            if (hi_len == st_at) stretch = 1'b1;
            if (hi_len == st_at + st_len) stretch = 1'b0;
            hi_len++;
            @(negedge clk);
        end
        stretch = 1'b0;
    endtask

    task automatic run_all();
        int lo, hi, so, ex;
        bit hf;
        int sh, sl, fh, fl, hd;
        logic [1:0] sp;

        // reset state (R6)
        #5;
        check(!scl_pull_low && !lo_edge && !hi_edge && !sda_go, "R6 reset outputs", scl_pull_low, 0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_pull_low, "R6 idle after reset", scl_pull_low, 0);

        // standard pair, first phase low
        reconfig(10, 20, 7, 9, 5, 2'b00);
        check(lo_edge && scl_pull_low, "R6 first phase low", lo_edge, 1);
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        check(lo == 21, "R1 std low", lo, 21);
        check(hi == 13, "R2 std high", hi, 13);
        check(so == 5, "R8 sda offset", so, 5);
        check(hf && ex == 0, "R9 single edge pulses", ex, 0);

        // fast pair with two codes
        reconfig(10, 20, 7, 9, 5, 2'b10);
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        check(lo == 10 && hi == 10, "R3 fast pair sel=2", lo * 100 + hi, 1010);
        reconfig(10, 20, 7, 9, 5, 2'b11);
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        check(lo == 10 && hi == 10, "R3 fast pair sel=3", lo * 100 + hi, 1010);

        // clamping and hold zero
        reconfig(2, 3, 0, 0, 0, 2'b00);
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        check(lo == 9, "R4 low clamp", lo, 9);
        check(hi == 9, "R4 high clamp", hi, 9);
        check(so == 1, "R8 hold zero acts as one", so, 1);
        reconfig(5, 7, 0, 0, 1, 2'b00);
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        check(lo == 9 && hi == 9, "R4 just below minimum", lo * 100 + hi, 909);
        reconfig(6, 8, 0, 0, 1, 2'b00);
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        check(lo == 9 && hi == 9, "R4 at minimum", lo * 100 + hi, 909);

        // stretching
        reconfig(10, 20, 7, 9, 5, 2'b00);
        measure(-1, 2, 5, lo, hi, so, ex, hf);
        check(hi == 18, "R5 stretch adds cycles", hi, 18);
        measure(-1, 0, 1, lo, hi, so, ex, hf);
        check(hi == 14, "R5 stretch on first high cycle", hi, 14);

        // speed change mid-phase
        measure(2, -1, 0, lo, hi, so, ex, hf);
        check(lo == 21 && hi == 10, "R3 change at phase boundary", lo * 100 + hi, 2110);
        speed_sel = 2'b00;
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        check(lo == 21 && hi == 13, "R3 back to standard", lo * 100 + hi, 2113);

        // writes while enabled ignored
        std_hcnt = 30; std_lcnt = 40; sda_hold = 9;
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        check(lo == 21 && hi == 13 && so == 5, "R7 enabled write ignored", lo * 100 + hi, 2113);
        reconfig(30, 40, 7, 9, 9, 2'b00);
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        check(lo == 41 && hi == 33 && so == 9, "R7 loads when disabled", lo * 100 + hi, 4133);

        // hold longer than low phase
        reconfig(10, 20, 7, 9, 100, 2'b00);
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        check(so == 20, "R8 hold past low end", so, 20);

        // large count
        reconfig(10, 300, 7, 9, 3, 2'b00);
        measure(-1, -1, 0, lo, hi, so, ex, hf);
        check(lo == 301, "R1 large low count", lo, 301);

        // disable mid low phase
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!scl_pull_low, "R6 release on disable", scl_pull_low, 0);
        ex = 0;
        repeat (5) begin
            if (scl_pull_low || lo_edge || hi_edge || sda_go) ex++;
            @(negedge clk);
        end
        check(ex == 0, "R6 quiet while disabled", ex, 0);

        // constrained random
        for (int i = 0; i < 10; i++) begin
            sh = int'($urandom_range(0, 40)); sl = int'($urandom_range(0, 40));
            fh = int'($urandom_range(0, 40)); fl = int'($urandom_range(0, 40));
            hd = int'($urandom_range(0, 50)); sp = 2'($urandom_range(0, 3));
            reconfig(sh, sl, fh, fl, hd, sp);
            measure(-1, -1, 0, lo, hi, so, ex, hf);
            if (sp == 2'b00) begin
                check(lo == f_lo(sl), "R1 random low", lo, f_lo(sl));
                check(hi == f_hi(sh), "R2 random high", hi, f_hi(sh));
            end else begin
                check(lo == f_lo(fl), "R3 random fast low", lo, f_lo(fl));
                check(hi == f_hi(fh), "R3 random fast high", hi, f_hi(fh));
            end
            check(so == f_sda(hd, lo), "R8 random hold", so, f_sda(hd, lo));
            check(hf && ex == 0, "R9 random edges", ex, 0);
        end
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5C1D_0042));
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule